// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This block gathers interrupt request wires from a set of devices and turns them into a single vectored request for a small processor. A rising edge on a device wire latches a pending flag for that device. Software can also set pending flags directly to raise an interrupt on purpose. A pending flag is offered to the processor only when three conditions hold: the device is enabled, the global enable is set, and the device's urgency level is above a programmable threshold. A separate non-maskable wire skips all of these gates.

The processor takes a request with an acknowledge strobe. At that moment the controller clears the chosen pending flag and drops the global enable. It also pushes the urgency level of the new handler, together with the previous global enable, onto an internal nesting stack. A return strobe pops the stack and restores the saved global enable. While a handler runs, only a strictly more urgent request can break in, and only if software has set the global enable again. Requests that have to wait are offered in the cycle right after the return, so the controller never drops back to the idle level between two handlers.

Each device has an urgency level. Levels are either fixed by device index or held in writable registers, selected by a parameter. A larger level is more urgent.

Top module: `ic_nest_ctrl`

## Requirements
- R1: A rising edge on `irq_i[i]` sets `pend_o[i]` after the next clock edge. The flag stays set until that source is acknowledged.
- R2: While `gie_o` is 0, `irq_req_o` is never raised for a maskable source.
- R3: An acknowledge that meets a raised request has these effects at that clock edge: `gie_o` goes to 0 and `depth_o` goes up by one. A return while `depth_o` is above 0 lowers `depth_o` by one and restores `gie_o` to the value it held when that level was entered.
- R4: A request that became pending during a handler and is eligible at the outer level is presented in the cycle right after the return edge.
- R5: While a handler runs, a request is presented only if its level is strictly greater than the running level. A request at an equal or lower level waits.
- R6: A write of `swset_data_i` with `swset_wr_i` sets the pending flags of the marked sources exactly as a hardware edge would. A source whose enable is 0 stays pending but is not presented.
- R7: A maskable source whose level is less than or equal to the threshold is never presented.
- R8: A rising edge on `nmi_i` makes the controller present vector `N_SRC`, whatever the values of the global enable, the source enables and the threshold. It is held back only by a running non-maskable handler or by a full stack.
- R9: Among eligible sources, the one with the highest level is presented. On equal levels, the lowest index wins. The level of source i resets to `N_SRC - i`, and a write with `prio_wr_i` replaces it with `prio_data_i` when the programmable variant is built.
- R10: When `depth_o` equals `STACK_DEPTH`, no request is presented. A return while `depth_o` is 0 has no effect.
- R11: An acknowledge clears the pending flag of the presented vector. An acknowledge with no request presented is ignored. When acknowledge and return arrive in the same cycle, only the return acts.
- R12: After reset, all of the following are 0: pending flags, enables, threshold, `gie_o`, `depth_o` and `irq_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Device request wires, edge sensed |
| nmi_i | input | 1 | Non-maskable request wire, edge sensed |
| en_wr_i | input | 1 | Write strobe for the source enables |
| en_data_i | input | N_SRC | New source enable mask |
| thr_wr_i | input | 1 | Write strobe for the threshold |
| thr_data_i | input | PRIO_W | New threshold level |
| gie_wr_i | input | 1 | Write strobe for the global enable |
| gie_data_i | input | 1 | New global enable value |
| swset_wr_i | input | 1 | Strobe to set pending flags from software |
| swset_data_i | input | N_SRC | Mask of pending flags to set |
| prio_wr_i | input | 1 | Write strobe for one source level |
| prio_idx_i | input | IDX_W | Source whose level is written |
| prio_data_i | input | PRIO_W | New level for that source |
| ack_i | input | 1 | Processor acknowledge strobe |
| ret_i | input | 1 | Processor return-from-interrupt strobe |
| irq_req_o | output | 1 | Request presented to the processor |
| irq_vec_o | output | VEC_W | Vector number; N_SRC is the non-maskable vector |
| pend_o | output | N_SRC | Pending flags of the maskable sources |
| gie_o | output | 1 | Current global enable |
| depth_o | output | DEPTH_W | Number of handlers on the nesting stack |

## Verification
The assertions check, on every cycle, the rules that hold cycle by cycle. A presented maskable request implies a set global enable, lies above the threshold and is more urgent than the running handler. An acknowledge always clears the global enable. A pending flag holds until it is cleared. The stack is never pushed when full and never popped when empty. Only the bench's scenarios can show the behaviours that span several cycles: the global enable saved at entry comes back after the return; tail-chaining happens in the exact cycle after a return; a software-set flag behaves like a hardware edge; ties are resolved by index; and the non-maskable request wins with every mask closed. The bench drives these cases directly and then runs a long random sequence against a reference model written from the requirements.

// File: rtl/ic_pkg.sv
package ic_pkg;
   // operation applied to the nesting stack in a cycle
   typedef enum logic [1:0] {
      STK_HOLD = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2
   } stk_op_e;
endpackage

// File: rtl/ic_pend_latch.sv
module ic_pend_latch #(
   parameter int N = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] line_i,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   if (N < 1) begin : g_chk_n
      $error("ic_pend_latch: N must be at least 1");
   end

   for (genvar g = 0; g < N; g++) begin : g_bit
      logic line_q;
      logic pend_q;
      logic rise;

      assign rise = line_i[g] & ~line_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            line_q <= 1'b0;
            pend_q <= 1'b0;
         end else begin
            line_q <= line_i[g];
            // a fresh event in the clearing cycle survives
            pend_q <= (pend_q & ~clr_i[g]) | rise | set_i[g];
         end
      end

      assign pend_o[g] = pend_q;

      AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (pend_q && !clr_i[g]) |=> pend_q); // R1
   end
endmodule

// File: rtl/ic_arbiter.sv
module ic_arbiter #(
   parameter int N     = 8,
   parameter int LVL_W = 5,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]            cand_i,
   input  logic [N-1:0][LVL_W-1:0] lvl_i,
   output logic                    hit_o,
   output logic [IDX_W-1:0]        idx_o,
   output logic [LVL_W-1:0]        lvl_o
);
   if (N < 2) begin : g_chk_n
      $error("ic_arbiter: N must be at least 2");
   end

   // scan from the top index down; >= lets a lower index take a tie
   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      lvl_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (cand_i[i] && (!hit_o || lvl_i[i] >= lvl_o)) begin
            hit_o = 1'b1;
            idx_o = IDX_W'(i);
            lvl_o = lvl_i[i];
         end
      end
   end
endmodule

// File: rtl/ic_nest_stack.sv
module ic_nest_stack
   import ic_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int LVL_W = 5,
   localparam int DEPTH_W = $clog2(DEPTH + 1),
   localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  stk_op_e            op_i,
   input  logic               push_gie_i,
   input  logic [LVL_W-1:0]   push_lvl_i,
   output logic [DEPTH_W-1:0] depth_o,
   output logic               full_o,
   output logic               top_gie_o,
   output logic [LVL_W-1:0]   top_lvl_o
);
   if (DEPTH < 1) begin : g_chk_depth
      $error("ic_nest_stack: DEPTH must be at least 1");
   end

   logic [DEPTH-1:0]            gie_mem;
   logic [DEPTH-1:0][LVL_W-1:0] lvl_mem;
   logic [DEPTH_W-1:0]          sp_q;
   logic [PTR_W-1:0]            wr_ptr;
   logic [PTR_W-1:0]            top_ptr;
   logic                        empty;

   assign empty   = (sp_q == '0);
   assign full_o  = (sp_q == DEPTH_W'(DEPTH));
   assign wr_ptr  = PTR_W'(sp_q);
   assign top_ptr = PTR_W'(sp_q - 1'b1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sp_q    <= '0;
         gie_mem <= '0;
         lvl_mem <= '0;
      end else begin
         unique case (op_i)
            STK_PUSH: if (!full_o) begin
               gie_mem[wr_ptr] <= push_gie_i;
               lvl_mem[wr_ptr] <= push_lvl_i;
               sp_q            <= sp_q + 1'b1;
            end
            STK_POP: if (!empty) begin
               sp_q <= sp_q - 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign depth_o   = sp_q;
   assign top_gie_o = empty ? 1'b0 : gie_mem[top_ptr];
   assign top_lvl_o = empty ? '0 : lvl_mem[top_ptr];

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_o |-> (op_i != STK_PUSH)); // R10
   AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      empty |-> (op_i != STK_POP)); // R10
endmodule

// File: rtl/ic_nest_ctrl.sv
module ic_nest_ctrl
   import ic_pkg::*;
#(
   parameter int N_SRC       = 8,
   parameter int PRIO_W      = 4,
   parameter int STACK_DEPTH = 8,
   parameter bit PRIO_PROG   = 1'b1,
   localparam int IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int VEC_W   = $clog2(N_SRC + 1),
   localparam int LVL_W   = PRIO_W + 1,
   localparam int DEPTH_W = $clog2(STACK_DEPTH + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [N_SRC-1:0]   irq_i,
   input  logic               nmi_i,
   input  logic               en_wr_i,
   input  logic [N_SRC-1:0]   en_data_i,
   input  logic               thr_wr_i,
   input  logic [PRIO_W-1:0]  thr_data_i,
   input  logic               gie_wr_i,
   input  logic               gie_data_i,
   input  logic               swset_wr_i,
   input  logic [N_SRC-1:0]   swset_data_i,
   input  logic               prio_wr_i,
   input  logic [IDX_W-1:0]   prio_idx_i,
   input  logic [PRIO_W-1:0]  prio_data_i,
   input  logic               ack_i,
   input  logic               ret_i,
   output logic               irq_req_o,
   output logic [VEC_W-1:0]   irq_vec_o,
   output logic [N_SRC-1:0]   pend_o,
   output logic               gie_o,
   output logic [DEPTH_W-1:0] depth_o
);
   localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(1) << PRIO_W;
   localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(N_SRC);

   if (N_SRC < 2) begin : g_chk_src
      $error("ic_nest_ctrl: N_SRC must be at least 2");
   end
   if (PRIO_W < $clog2(N_SRC + 1)) begin : g_chk_prio
      $error("ic_nest_ctrl: PRIO_W too narrow for the index levels");
   end
   if (STACK_DEPTH < 1) begin : g_chk_stack
      $error("ic_nest_ctrl: STACK_DEPTH must be at least 1");
   end

   // ---------------- configuration state ----------------
   logic [N_SRC-1:0]  en_q;
   logic [PRIO_W-1:0] thr_q;
   logic              gie_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q  <= '0;
         thr_q <= '0;
      end else begin
         if (en_wr_i)  en_q  <= en_data_i;
         if (thr_wr_i) thr_q <= thr_data_i;
      end
   end

   // ---------------- source levels ----------------
   logic [N_SRC-1:0][LVL_W-1:0] lvl;

   if (PRIO_PROG) begin : g_prio_reg
      logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
      for (genvar g = 0; g < N_SRC; g++) begin : g_src
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               prio_q[g] <= PRIO_W'(N_SRC - g);
            end else if (prio_wr_i && prio_idx_i == IDX_W'(g)) begin
               prio_q[g] <= prio_data_i;
            end
         end
         assign lvl[g] = {1'b0, prio_q[g]};
      end
   end else begin : g_prio_fixed
      logic unused_prio_cfg;
      assign unused_prio_cfg = ^{prio_wr_i, prio_idx_i, prio_data_i};
      for (genvar g = 0; g < N_SRC; g++) begin : g_src
         assign lvl[g] = LVL_W'(N_SRC - g);
      end
   end

   // ---------------- pending flags ----------------
   logic [N_SRC-1:0] clr_src;
   logic             clr_nmi;
   logic             nmi_pend;

   ic_pend_latch #(.N(N_SRC)) u_src_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (irq_i),
      .set_i  (swset_wr_i ? swset_data_i : '0),
      .clr_i  (clr_src),
      .pend_o (pend_o)
   );

   ic_pend_latch #(.N(1)) u_nmi_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (nmi_i),
      .set_i  (1'b0),
      .clr_i  (clr_nmi),
      .pend_o (nmi_pend)
   );

   // ---------------- nesting stack ----------------
   stk_op_e            stk_op;
   logic               stk_full;
   logic               stk_top_gie;
   logic [LVL_W-1:0]   stk_top_lvl;
   logic [LVL_W-1:0]   sel_lvl;
   logic [DEPTH_W-1:0] depth;

   ic_nest_stack #(.DEPTH(STACK_DEPTH), .LVL_W(LVL_W)) u_stack (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .op_i       (stk_op),
      .push_gie_i (gie_q),
      .push_lvl_i (sel_lvl),
      .depth_o    (depth),
      .full_o     (stk_full),
      .top_gie_o  (stk_top_gie),
      .top_lvl_o  (stk_top_lvl)
   );

   // ---------------- eligibility and arbitration ----------------
   logic [LVL_W-1:0] run_lvl;
   logic [N_SRC-1:0] cand;
   logic             arb_hit;
   logic [IDX_W-1:0] arb_idx;
   logic [LVL_W-1:0] arb_lvl;
   logic             nmi_ok;

   assign run_lvl = (depth == '0) ? '0 : stk_top_lvl;

   for (genvar g = 0; g < N_SRC; g++) begin : g_cand
      assign cand[g] = pend_o[g] & en_q[g] & gie_q
                     & (lvl[g] > {1'b0, thr_q})
                     & (lvl[g] > run_lvl);
   end

   ic_arbiter #(.N(N_SRC), .LVL_W(LVL_W)) u_arb (
      .cand_i (cand),
      .lvl_i  (lvl),
      .hit_o  (arb_hit),
      .idx_o  (arb_idx),
      .lvl_o  (arb_lvl)
   );

   assign nmi_ok    = nmi_pend & (NMI_LVL > run_lvl);
   assign irq_req_o = ~stk_full & (nmi_ok | arb_hit);
   assign irq_vec_o = nmi_ok ? NMI_VEC : VEC_W'(arb_idx);
   assign sel_lvl   = nmi_ok ? NMI_LVL : arb_lvl;

   // ---------------- processor handshake ----------------
   logic ret_ok;
   logic ack_ok;

   assign ret_ok = ret_i & (depth != '0);
   assign ack_ok = ack_i & irq_req_o & ~ret_i;

   always_comb begin
      if (ret_ok)      stk_op = STK_POP;
      else if (ack_ok) stk_op = STK_PUSH;
      else             stk_op = STK_HOLD;
   end

   assign clr_nmi = ack_ok & nmi_ok;
   assign clr_src = (ack_ok && !nmi_ok) ? ({{(N_SRC-1){1'b0}}, 1'b1} << arb_idx) : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       gie_q <= 1'b0;
      else if (ret_ok)   gie_q <= stk_top_gie;
      else if (ack_ok)   gie_q <= 1'b0;
      else if (gie_wr_i) gie_q <= gie_data_i;
   end

   assign gie_o   = gie_q;
   assign depth_o = depth;

   AST_MASKED_WHEN_GIE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_req_o && irq_vec_o != NMI_VEC) |-> gie_o); // R2
   AST_ENTRY_CLEARS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && irq_req_o && !ret_i) |=> !gie_o); // R3
   AST_RET_POPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_i && depth_o != '0) |=> (depth_o == $past(depth_o) - 1'b1)); // R3
   AST_STRICT_PREEMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_req_o && depth_o != '0) |-> (sel_lvl > stk_top_lvl)); // R5
   AST_THRESHOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_req_o && irq_vec_o != NMI_VEC) |-> (sel_lvl > {1'b0, thr_q})); // R7
   AST_FULL_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (depth_o == DEPTH_W'(STACK_DEPTH)) |-> !irq_req_o); // R10
endmodule

// File: tb/ic_nest_ctrl_tb.sv
module ic_nest_ctrl_tb_top;
   localparam int N       = 8;
   localparam int PW      = 4;
   localparam int DEPTH   = 8;
   localparam int IDX_W   = $clog2(N);
   localparam int VEC_W   = $clog2(N + 1);
   localparam int DEPTH_W = $clog2(DEPTH + 1);
   localparam int NMI_LVL = 1 << PW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [N-1:0]       irq = '0;
   logic               nmi = 1'b0;
   logic               en_wr = 1'b0;
   logic [N-1:0]       en_d = '0;
   logic               thr_wr = 1'b0;
   logic [PW-1:0]      thr_d = '0;
   logic               gie_wr = 1'b0;
   logic               gie_d = 1'b0;
   logic               sw_wr = 1'b0;
   logic [N-1:0]       sw_d = '0;
   logic               pr_wr = 1'b0;
   logic [IDX_W-1:0]   pr_idx = '0;
   logic [PW-1:0]      pr_d = '0;
   logic               ack = 1'b0;
   logic               ret = 1'b0;
   logic               req;
   logic [VEC_W-1:0]   vec;
   logic [N-1:0]       pend;
   logic               gie;
   logic [DEPTH_W-1:0] depth;

   ic_nest_ctrl #(.N_SRC(N), .PRIO_W(PW), .STACK_DEPTH(DEPTH), .PRIO_PROG(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .nmi_i(nmi),
      .en_wr_i(en_wr), .en_data_i(en_d), .thr_wr_i(thr_wr), .thr_data_i(thr_d),
      .gie_wr_i(gie_wr), .gie_data_i(gie_d), .swset_wr_i(sw_wr), .swset_data_i(sw_d),
      .prio_wr_i(pr_wr), .prio_idx_i(pr_idx), .prio_data_i(pr_d),
      .ack_i(ack), .ret_i(ret), .irq_req_o(req), .irq_vec_o(vec),
      .pend_o(pend), .gie_o(gie), .depth_o(depth)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // reference model state
   bit m_pend[N];
   bit m_en[N];
   int m_lvl[N];
   bit m_iprev[N];
   bit m_npend, m_nprev, m_gie;
   int m_thr, m_sp;
   bit m_sg[DEPTH];
   int m_sl[DEPTH];

   task automatic chk(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin
         m_pend[i] = 0; m_en[i] = 0; m_lvl[i] = N - i; m_iprev[i] = 0;
      end
      m_npend = 0; m_nprev = 0; m_gie = 0; m_thr = 0; m_sp = 0;
   endtask

   task automatic model_out(output bit r, output int v);
      int cur, bl;
      r = 0; v = 0; bl = -1;
      cur = (m_sp > 0) ? m_sl[m_sp-1] : 0;
      if (m_sp == DEPTH) return;
      if (m_npend && NMI_LVL > cur) begin r = 1; v = N; return; end
      for (int i = 0; i < N; i++)
         if (m_pend[i] && m_en[i] && m_gie && m_lvl[i] > m_thr && m_lvl[i] > cur && m_lvl[i] > bl) begin
            r = 1; v = i; bl = m_lvl[i];
         end
   endtask

   task automatic model_step();
      bit r, ret_ok, ack_ok;
      int v;
      model_out(r, v);
      ret_ok = ret && m_sp > 0;
      ack_ok = ack && r && !ret;
      for (int i = 0; i < N; i++) begin
         if (ack_ok && v == i) m_pend[i] = 0;
         if ((irq[i] && !m_iprev[i]) || (sw_wr && sw_d[i])) m_pend[i] = 1;
         m_iprev[i] = irq[i];
      end
      if (ack_ok && v == N) m_npend = 0;
      if (nmi && !m_nprev) m_npend = 1;
      m_nprev = nmi;
      if (ret_ok) begin
         m_gie = m_sg[m_sp-1]; m_sp--;
      end else if (ack_ok) begin
         m_sg[m_sp] = m_gie; m_sl[m_sp] = (v == N) ? NMI_LVL : m_lvl[v]; m_sp++; m_gie = 0;
      end else if (gie_wr) m_gie = gie_d;
      if (en_wr) for (int i = 0; i < N; i++) m_en[i] = en_d[i];
      if (thr_wr) m_thr = thr_d;
      if (pr_wr) m_lvl[pr_idx] = pr_d;
   endtask

   task automatic compare();
      bit r;
      int v;
      model_out(r, v);
      chk("R9 req", req, r);
      if (r) chk("R9 vec", vec, v);
      for (int i = 0; i < N; i++) chk("R1 pend", pend[i], m_pend[i]);
      chk("R3 gie", gie, m_gie);
      chk("R3 depth", depth, m_sp);
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
      en_wr = 0; thr_wr = 0; gie_wr = 0; sw_wr = 0; pr_wr = 0; ack = 0; ret = 0;
   endtask

   task automatic do_reset();
      rst_n = 0; irq = '0; nmi = 0;
      model_reset();
      @(posedge clk); @(negedge clk);
      chk("R12 req", req, 0); chk("R12 pend", pend, 0);
      chk("R12 gie", gie, 0); chk("R12 depth", depth, 0);
      rst_n = 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      @(negedge clk);
      do_reset();

      // R10: return with empty stack is ignored
      ret = 1; cyc(); chk("R10 ret empty", depth, 0);

      en_wr = 1; en_d = '1; gie_wr = 1; gie_d = 1; cyc();
      irq[3] = 1; cyc();
      chk("R1 pend3", pend[3], 1); chk("R9 vec3", vec, 3);
      ack = 1; cyc();
      chk("R3 gie off", gie, 0); chk("R3 depth1", depth, 1); chk("R11 clr3", pend[3], 0);
      irq[1] = 1; cyc(); chk("R2 gated", req, 0);
      gie_wr = 1; gie_d = 1; cyc(); chk("R5 preempt vec1", vec, 1);
      ack = 1; cyc(); chk("R5 depth2", depth, 2);
      irq[2] = 1; cyc(); chk("R5 lower waits", req, 0);
      ret = 1; cyc();
      chk("R4 depth", depth, 1); chk("R3 gie restored", gie, 1);
      chk("R4 tail req", req, 1); chk("R4 tail vec", vec, 2);
      ack = 1; ret = 1; cyc(); chk("R11 ret wins", depth, 0);
      ack = 1; cyc(); ret = 1; cyc(); chk("R3 gie back", gie, 1);

      // R6: software set, disabled source stays pending
      en_wr = 1; en_d = ~(N'(1) << 4); sw_wr = 1; sw_d = N'(1) << 4; cyc();
      chk("R6 pend4", pend[4], 1); chk("R6 disabled", req, 0);
      en_wr = 1; en_d = '1; cyc(); chk("R6 vec4", vec, 4);
      ack = 1; cyc(); ret = 1; cyc();

      // R7 threshold, R9 tie
      thr_wr = 1; thr_d = 6; sw_wr = 1; sw_d = 8'b0000_0110; cyc();
      chk("R7 above thr", vec, 1);
      thr_wr = 1; thr_d = 7; cyc(); chk("R7 blocked", req, 0);
      thr_wr = 1; thr_d = 0; cyc(); ack = 1; cyc(); ret = 1; cyc();
      pr_wr = 1; pr_idx = 5; pr_d = 6; sw_wr = 1; sw_d = N'(1) << 5; cyc();
      chk("R9 tie low idx", vec, 2);
      ack = 1; cyc(); ret = 1; cyc(); chk("R9 then 5", vec, 5);
      ack = 1; cyc(); ret = 1; cyc();

      // R8: NMI with every mask closed
      gie_wr = 1; gie_d = 0; en_wr = 1; en_d = '0; thr_wr = 1; thr_d = '1; cyc();
      nmi = 1; cyc(); chk("R8 nmi req", req, 1); chk("R8 nmi vec", vec, N);
      ack = 1; cyc(); ret = 1; cyc(); nmi = 0; cyc();

      // R10: fill the stack
      do_reset();
      en_wr = 1; en_d = '1; cyc();
      for (int k = N - 1; k >= 0; k--) begin
         irq[k] = 1; gie_wr = 1; gie_d = 1; cyc();
         ack = 1; cyc();
      end
      chk("R10 full depth", depth, DEPTH);
      nmi = 1; cyc(); chk("R10 full blocks", req, 0);
      ret = 1; cyc(); chk("R8 nmi after pop", vec, N); chk("R10 req", req, 1);

      // random phase
      do_reset();
      for (int c = 0; c < 4000; c++) begin
         bit r;
         int v;
         model_out(r, v);
         if ($urandom_range(0, 3) == 0) irq[$urandom_range(0, N-1)] ^= 1'b1;
         if ($urandom_range(0, 40) == 0) nmi = ~nmi;
         if ($urandom_range(0, 9) == 0) begin en_wr = 1; en_d = N'($urandom); end
         if ($urandom_range(0, 19) == 0) begin thr_wr = 1; thr_d = PW'($urandom_range(0, 4)); end
         if ($urandom_range(0, 4) == 0) begin gie_wr = 1; gie_d = ($urandom_range(0, 3) != 0); end
         if ($urandom_range(0, 12) == 0) begin sw_wr = 1; sw_d = N'($urandom); end
         if ($urandom_range(0, 25) == 0) begin
            pr_wr = 1; pr_idx = IDX_W'($urandom_range(0, N-1)); pr_d = PW'($urandom);
         end
         ack = r ? ($urandom_range(0, 1) == 1) : ($urandom_range(0, 9) == 0);
         ret = ($urandom_range(0, 5) == 0);
         cyc();
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule